// File: doc/BRIEF.md
# Fractional-step time-of-day counter

This block keeps the running time of a precision time protocol clock. Time is held as a seconds count, a nanoseconds count below one second, and a 32-bit fraction of a nanosecond in units of 2^-32 ns. On every clock edge the nanosecond-plus-fraction pair grows by a programmable increment. When it reaches a full second it folds back and the seconds count steps up by one.

The increment has three parts. The first is a whole-nanosecond step. The second is a signed fractional step, so a step of 3.5 ns is written as 4 whole with a fraction of -0.5. The third is a signed frequency trim that slows or speeds the clock by up to about half a nanosecond per tick. Software loads the step through three 16-bit writes, and the new step goes live only when its low fractional half is written. The trim halves are staged the same way and go live only on a separate load strobe. A level-sensitive active-low software reset holds the time at zero while leaving the programmed step and trim in place. After a hardware reset the step is 3 ns with no fraction and no trim, which suits a 333.33 MHz counting clock.

Top module: `tod_counter`

## Requirements
- R1: After hardware reset (rst_n low) the seconds, nanoseconds and fraction outputs are all zero, the active step is 3 ns whole with zero fraction, the trim is zero, and the staged step halves hold those same values.
- R2: While soft_rst_n is low the three time outputs are forced to zero on every edge; the step and trim registers keep their contents, and counting resumes on the first edge that samples soft_rst_n high.
- R3: On each edge with soft_rst_n high, the 62-bit value {tod_ns, tod_frac} grows by step_whole*2^32 + signed(step_frac) + signed(trim), where the two signed terms are 32-bit two's complement in units of 2^-32 ns.
- R4: When the grown nanosecond value reaches or passes 1,000,000,000 ns, 10^9 ns is taken off in the same edge and tod_sec rises by one; tod_ns never shows a value of 10^9 or more, and tod_sec changes at no other edge except a reset.
- R5: reg_sel 0 stages the whole-nanosecond step (reg_wdata[15:0]) and reg_sel 1 stages fraction bits [31:16]; neither changes the count. A write with reg_sel 2 supplies fraction bits [15:0] and makes the staged whole and high half plus this low half the active step, used from the next edge on.
- R6: reg_sel 3 stages trim bits [31:16] and reg_sel 4 stages trim bits [15:0]; these writes do not change the count. A high pulse on trim_load copies the staged 32-bit trim into the active trim, used from the next edge on.
- R7: A fractional step with bit 31 set counts as negative: whole 4 with fraction 0x8000_0000 advances by exactly 3.5 ns per edge.
- R8: When the summed increment of R3 is negative it is taken as zero, so the time outputs stay still and never move backward.
- R9: Writes with reg_sel 5, 6 or 7 change neither the count nor any step or trim register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| soft_rst_n | input | 1 | Software hold, active low; time forced to zero while low |
| reg_wr | input | 1 | Register write strobe for one cycle |
| reg_sel | input | 3 | Register select: 0 step whole, 1 step fraction high, 2 step fraction low (commits), 3 trim high, 4 trim low |
| reg_wdata | input | 16 | Write data for the selected half |
| trim_load | input | 1 | Makes the staged trim active |
| tod_sec | output | 48 | Seconds count |
| tod_ns | output | 30 | Nanoseconds within the second |
| tod_frac | output | 32 | Fraction of a nanosecond, units of 2^-32 ns |

## Verification
The monotonic and one-fold-per-edge properties assume the whole step stays far below one second and that software never stages a value it expects to be live before the committing write or the trim strobe. The stimulus keeps the whole step at or below 65535 ns, so at most one second boundary is crossed per edge, and it never issues a trim write and trim_load in the same cycle. Negative summed increments are produced on purpose only in the clamp case, where the properties still hold because the time then stays still.

// File: rtl/tod_pkg.sv
package tod_pkg;

  // Register select codes for the 16-bit write port.
  typedef enum logic [2:0] {
    SEL_STEP_WHOLE = 3'd0,
    SEL_STEP_FHI   = 3'd1,
    SEL_STEP_FLO   = 3'd2,
    SEL_TRIM_HI    = 3'd3,
    SEL_TRIM_LO    = 3'd4
  } tod_sel_e;

  localparam int SEL_W = 3;

endpackage

// File: rtl/tod_step_regs.sv
module tod_step_regs
  import tod_pkg::*;
#(
  parameter int STEP_NS_W  = 16,
  parameter int FRAC_W     = 32,
  parameter int RESET_NS   = 3,
  parameter int RESET_FRAC = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [SEL_W-1:0]       wr_sel,
  input  logic [FRAC_W/2-1:0]    wr_data,
  output logic [STEP_NS_W-1:0]   act_ns,
  output logic [FRAC_W-1:0]      act_frac,
  output logic                   commit
);
  localparam int HALF_W = FRAC_W / 2;
  localparam logic [STEP_NS_W-1:0] RST_NS   = STEP_NS_W'(RESET_NS);
  localparam logic [FRAC_W-1:0]    RST_FRAC = FRAC_W'(RESET_FRAC);

  logic [STEP_NS_W-1:0] stg_ns;
  logic [HALF_W-1:0]    stg_fhi;
  logic                 wr_ns, wr_fhi;

  assign wr_ns  = wr_en && (wr_sel == SEL_STEP_WHOLE);
  assign wr_fhi = wr_en && (wr_sel == SEL_STEP_FHI);
  assign commit = wr_en && (wr_sel == SEL_STEP_FLO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_ns   <= RST_NS;
      stg_fhi  <= RST_FRAC[FRAC_W-1:HALF_W];
      act_ns   <= RST_NS;
      act_frac <= RST_FRAC;
    end else begin
      if (wr_ns)  stg_ns  <= wr_data[STEP_NS_W-1:0];
      if (wr_fhi) stg_fhi <= wr_data;
      if (commit) begin
        act_ns   <= stg_ns;
        act_frac <= {stg_fhi, wr_data};
      end
    end
  end

endmodule

// File: rtl/tod_trim_reg.sv
module tod_trim_reg
  import tod_pkg::*;
#(
  parameter int FRAC_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [FRAC_W/2-1:0] wr_data,
  input  logic                load,
  output logic [FRAC_W-1:0]   act_trim
);
  localparam int HALF_W = FRAC_W / 2;

  logic [HALF_W-1:0] stg_half [2];
  logic [1:0]        half_we;

  // One staging register per half; index 1 is the high half.
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half_we[h] = wr_en &&
                        (wr_sel == ((h == 1) ? SEL_TRIM_HI : SEL_TRIM_LO));
    always_ff @(posedge clk) begin
      if (!rst_n)          stg_half[h] <= '0;
      else if (half_we[h]) stg_half[h] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    act_trim <= '0;
    else if (load) act_trim <= {stg_half[1], stg_half[0]};
  end

endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 30,
  parameter int FRAC_W     = 32,
  parameter int STEP_NS_W  = 16,
  parameter int NS_PER_SEC = 1_000_000_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst_n,
  input  logic [STEP_NS_W-1:0] step_ns,
  input  logic [FRAC_W-1:0]    step_frac,
  input  logic [FRAC_W-1:0]    trim,
  output logic [SEC_W-1:0]     sec,
  output logic [NS_W-1:0]      ns,
  output logic [FRAC_W-1:0]    frac,
  output logic                 wrap_evt
);
  localparam int INC_W  = STEP_NS_W + FRAC_W + 2;
  localparam int MAG_W  = INC_W - 1;
  localparam int TIME_W = NS_W + FRAC_W;
  localparam int SUM_W  = TIME_W + 1;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(NS_PER_SEC) << FRAC_W;

  // Signed sum of the three increment parts; a negative total counts as zero.
  function automatic logic [MAG_W-1:0] step_increment(
    input logic [STEP_NS_W-1:0] whole,
    input logic [FRAC_W-1:0]    f_step,
    input logic [FRAC_W-1:0]    f_trim
  );
    logic signed [INC_W-1:0] w, f, t, s;
    w = $signed({2'b00, whole, {FRAC_W{1'b0}}});
    f = $signed({{(INC_W-FRAC_W){f_step[FRAC_W-1]}}, f_step});
    t = $signed({{(INC_W-FRAC_W){f_trim[FRAC_W-1]}}, f_trim});
    s = w + f + t;
    return s[INC_W-1] ? '0 : s[MAG_W-1:0];
  endfunction

  function automatic logic [SUM_W-1:0] time_sum(
    input logic [TIME_W-1:0] cur,
    input logic [MAG_W-1:0]  inc
  );
    return {1'b0, cur} + SUM_W'(inc);
  endfunction

  logic [TIME_W-1:0] cur_q, nxt;
  logic [MAG_W-1:0]  inc;
  logic [SUM_W-1:0]  sum;
  logic [SEC_W-1:0]  sec_q;

  always_comb begin
    inc      = step_increment(step_ns, step_frac, trim);
    sum      = time_sum(cur_q, inc);
    wrap_evt = (sum >= LIMIT);
    nxt      = wrap_evt ? TIME_W'(sum - LIMIT) : TIME_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !soft_rst_n) begin
      cur_q <= '0;
      sec_q <= '0;
    end else begin
      cur_q <= nxt;
      if (wrap_evt) sec_q <= sec_q + 1'b1;
    end
  end

  assign sec  = sec_q;
  assign ns   = cur_q[TIME_W-1:FRAC_W];
  assign frac = cur_q[FRAC_W-1:0];

endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int SEC_W           = 48,
  parameter int NS_W            = 30,
  parameter int FRAC_W          = 32,
  parameter int STEP_NS_W       = 16,
  parameter int NS_PER_SEC      = 1_000_000_000,
  parameter int RESET_STEP_NS   = 3,
  parameter int RESET_STEP_FRAC = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst_n,
  input  logic                reg_wr,
  input  logic [SEL_W-1:0]    reg_sel,
  input  logic [FRAC_W/2-1:0] reg_wdata,
  input  logic                trim_load,
  output logic [SEC_W-1:0]    tod_sec,
  output logic [NS_W-1:0]     tod_ns,
  output logic [FRAC_W-1:0]   tod_frac
);
  // Internal events named for the bound checker.
  logic [STEP_NS_W-1:0] step_ns_q;
  logic [FRAC_W-1:0]    step_frac_q;
  logic                 step_commit;
  logic [FRAC_W-1:0]    trim_q;
  logic                 wrap_evt;

  tod_step_regs #(
    .STEP_NS_W (STEP_NS_W),
    .FRAC_W    (FRAC_W),
    .RESET_NS  (RESET_STEP_NS),
    .RESET_FRAC(RESET_STEP_FRAC)
  ) step_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_sel  (reg_sel),
    .wr_data (reg_wdata),
    .act_ns  (step_ns_q),
    .act_frac(step_frac_q),
    .commit  (step_commit)
  );

  tod_trim_reg #(
    .FRAC_W(FRAC_W)
  ) trim_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_sel  (reg_sel),
    .wr_data (reg_wdata),
    .load    (trim_load),
    .act_trim(trim_q)
  );

  tod_accum #(
    .SEC_W     (SEC_W),
    .NS_W      (NS_W),
    .FRAC_W    (FRAC_W),
    .STEP_NS_W (STEP_NS_W),
    .NS_PER_SEC(NS_PER_SEC)
  ) accum_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst_n(soft_rst_n),
    .step_ns   (step_ns_q),
    .step_frac (step_frac_q),
    .trim      (trim_q),
    .sec       (tod_sec),
    .ns        (tod_ns),
    .frac      (tod_frac),
    .wrap_evt  (wrap_evt)
  );

endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 30,
  parameter int FRAC_W     = 32,
  parameter int STEP_NS_W  = 16,
  parameter int NS_PER_SEC = 1_000_000_000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 soft_rst_n,
  input logic                 trim_load,
  input logic [SEC_W-1:0]     tod_sec,
  input logic [NS_W-1:0]      tod_ns,
  input logic [FRAC_W-1:0]    tod_frac,
  input logic                 step_commit,
  input logic [STEP_NS_W-1:0] step_ns_q,
  input logic [FRAC_W-1:0]    step_frac_q,
  input logic [FRAC_W-1:0]    trim_q,
  input logic                 wrap_evt
);

  AST_NS_BELOW_SECOND: assert property (@(posedge clk) disable iff (!rst_n) (64'(tod_ns) < 64'(NS_PER_SEC))); // R4

  AST_SEC_STEPS_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (soft_rst_n && wrap_evt) |=> (tod_sec == SEC_W'($past(tod_sec) + 1'b1))); // R4

  AST_SEC_STILL_WITHOUT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (soft_rst_n && !wrap_evt) |=> $stable(tod_sec)); // R4

  AST_SOFT_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !soft_rst_n |=> (tod_sec == '0 && tod_ns == '0 && tod_frac == '0)); // R2

  AST_NEVER_BACKWARD: assert property (@(posedge clk) disable iff (!rst_n) (soft_rst_n && !wrap_evt) |=> ({tod_ns, tod_frac} >= $past({tod_ns, tod_frac}))); // R8

  AST_STEP_HELD_UNTIL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) !step_commit |=> ($stable(step_ns_q) && $stable(step_frac_q))); // R5

  AST_TRIM_HELD_UNTIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n) !trim_load |=> $stable(trim_q)); // R6

endmodule

bind tod_counter tod_counter_chk #(
  .SEC_W     (SEC_W),
  .NS_W      (NS_W),
  .FRAC_W    (FRAC_W),
  .STEP_NS_W (STEP_NS_W),
  .NS_PER_SEC(NS_PER_SEC)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst_n (soft_rst_n),
  .trim_load  (trim_load),
  .tod_sec    (tod_sec),
  .tod_ns     (tod_ns),
  .tod_frac   (tod_frac),
  .step_commit(step_commit),
  .step_ns_q  (step_ns_q),
  .step_frac_q(step_frac_q),
  .trim_q     (trim_q),
  .wrap_evt   (wrap_evt)
);

// File: tb/tod_counter_tb_top.sv
module tod_counter_tb_top;

  localparam int CLK_HALF = 10;  // 50 MHz

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic        trim_load = 1'b0;
  logic [47:0] tod_sec;
  logic [29:0] tod_ns;
  logic [31:0] tod_frac;

  int n_checks = 0;
  int n_fail   = 0;
  int n_wraps  = 0;

  always #(CLK_HALF) clk = ~clk;

  tod_counter dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst_n(soft_rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .trim_load (trim_load),
    .tod_sec   (tod_sec),
    .tod_ns    (tod_ns),
    .tod_frac  (tod_frac)
  );

  // ---------------- reference model: total time in 2^-32 ns units
  localparam logic [127:0] SEC_UNITS = 128'd1_000_000_000 << 32;

  logic [127:0] m_total;
  logic [15:0]  m_step_ns, m_stg_ns;
  logic [31:0]  m_step_frac, m_trim, m_stg_trim;
  logic [15:0]  m_stg_fhi;

  always @(posedge clk) begin
    longint inc;
    if (!rst_n) begin
      m_total     = '0;
      m_step_ns   = 16'd3;  m_stg_ns  = 16'd3;
      m_step_frac = '0;     m_stg_fhi = '0;
      m_trim      = '0;     m_stg_trim = '0;
    end else begin
      inc = (longint'(m_step_ns) <<< 32) + longint'($signed(m_step_frac))
            + longint'($signed(m_trim));
      if (inc < 0) inc = 0;
      if (soft_rst_n) m_total = m_total + 128'(unsigned'(inc));
      else            m_total = '0;
      if (trim_load) m_trim = m_stg_trim;
      if (reg_wr) begin
        case (reg_sel)
          3'd0: m_stg_ns = reg_wdata;
          3'd1: m_stg_fhi = reg_wdata;
          3'd2: begin m_step_ns = m_stg_ns; m_step_frac = {m_stg_fhi, reg_wdata}; end
          3'd3: m_stg_trim[31:16] = reg_wdata;
          3'd4: m_stg_trim[15:0] = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic check_state(string tag);
    logic [127:0] rem;
    logic [47:0]  e_sec;
    logic [29:0]  e_ns;
    logic [31:0]  e_frac;
    e_sec  = 48'(m_total / SEC_UNITS);
    rem    = m_total % SEC_UNITS;
    e_ns   = 30'(rem >> 32);
    e_frac = rem[31:0];
    n_checks++;
    if (tod_sec !== e_sec || tod_ns !== e_ns || tod_frac !== e_frac) begin
      n_fail++;
      $display("FAIL %s time sec=%0d ns=%0d frac=%h expected sec=%0d ns=%0d frac=%h",
               tag, tod_sec, tod_ns, tod_frac, e_sec, e_ns, e_frac);
    end
    if (tag == "R4") begin
      n_checks++;
      if (tod_ns >= 30'd1_000_000_000) begin
        n_fail++;
        $display("FAIL R4 ns range actual=%0d expected below 1000000000", tod_ns);
      end
    end
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_state(tag);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [15:0] d, string tag);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    check_state(tag);
    reg_wr = 1'b0;
  endtask

  task automatic prog_step(logic [15:0] whole, logic [31:0] f, string tag);
    wr(3'd0, whole, tag);
    wr(3'd1, f[31:16], tag);
    wr(3'd2, f[15:0], tag);
  endtask

  task automatic prog_trim(logic [31:0] t, string tag);
    wr(3'd3, t[31:16], tag);
    wr(3'd4, t[15:0], tag);
    run(6, tag);            // staged only: count must follow the old trim
    trim_load = 1'b1;
    @(negedge clk);
    check_state(tag);
    trim_load = 1'b0;
  endtask

  initial begin
    logic [47:0] sec_start;
    logic [15:0] whole_set [6];
    logic [31:0] frac_set  [4];
    whole_set = '{16'd1, 16'd2, 16'd3, 16'd5, 16'd1000, 16'd65535};
    frac_set  = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run(1, "R1");                       // reset state, all zero
    run(4, "R2");                       // software hold keeps zero
    soft_rst_n = 1'b1;
    run(20, "R1");                      // default 3 ns step
    run(10, "R3");

    // Staged step: whole and high half alone change nothing.
    wr(3'd0, 16'd7, "R5");
    run(5, "R5");
    wr(3'd1, 16'h4000, "R5");
    run(5, "R5");
    wr(3'd2, 16'h0000, "R5");           // 7.25 ns from the next edge
    run(40, "R3");

    // Negative fraction: 4 - 0.5 = 3.5 ns.
    prog_step(16'd4, 32'h8000_0000, "R7");
    run(40, "R7");

    // Trim: staged halves ignored until the load strobe.
    prog_trim(32'hFFFF_F000, "R6");
    run(30, "R6");
    prog_trim(32'h1234_5678, "R6");
    run(30, "R3");

    // Unused selects leave everything unchanged.
    wr(3'd5, 16'hFFFF, "R9");
    wr(3'd6, 16'hFFFF, "R9");
    wr(3'd7, 16'hFFFF, "R9");
    wr(3'd2, 16'h0000, "R9");           // commit reveals staged values untouched
    run(20, "R9");

    // Negative total increment clamps to zero.
    prog_step(16'd0, 32'h8000_0000, "R8");
    run(10, "R8");
    prog_trim(32'hC000_0000, "R8");
    run(20, "R8");
    prog_trim(32'h0000_0000, "R8");

    // Near-exhaustive sweep of step shapes.
    foreach (whole_set[w]) begin
      foreach (frac_set[f]) begin
        prog_step(whole_set[w], frac_set[f], "R3");
        run(20, "R3");
      end
    end

    // Second boundary: large step, several folds.
    prog_step(16'd65535, 32'hFFFF_FFFF, "R4");
    sec_start = tod_sec;
    for (int i = 0; i < 32000; i++) begin
      @(negedge clk);
      check_state("R4");
    end
    n_wraps = int'(tod_sec - sec_start);
    n_checks++;
    if (n_wraps < 2) begin
      n_fail++;
      $display("FAIL R4 seconds advanced actual=%0d expected at least 2", n_wraps);
    end

    // Software hold mid-run keeps the step registers.
    soft_rst_n = 1'b0;
    run(3, "R2");
    soft_rst_n = 1'b1;
    run(20, "R2");

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(2 * CLK_HALF * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule